// File: doc/BRIEF.md
# Asymmetric Dual-Issue Pairing Unit

This unit sits between decode and execution in an in-order core with two execution lanes. One lane takes integer-side work: ALU operations, branches, and every load or store, including floating-point loads and stores. The other lane takes floating-point computation: add, subtract, fused multiply-add, convert, multiply, divide and square root. Each cycle the unit looks at two pre-decoded slots. Slot 0 holds the older instruction and slot 1 the younger. The unit decides which slots issue and to which lane, and reports how many were consumed so that the fetch queue can advance.

The unit pairs only across the two classes. An integer-side instruction and an FP computation instruction may go out together in either slot order. Two instructions of one class never pair. The unit also tracks how long the FP lane stays occupied. Pipelined operations may follow each other every cycle. Double-precision multiply and multiply-add keep the lane closed for one extra cycle. Divide and square root keep it closed until an external completion strobe arrives.

The decision uses the current slot contents, the lane stalls and the occupancy state. The grants, slot-select flags and count are registered, so they appear the cycle after the inputs are presented.

Top module: `dual_issue_pair`

## Requirements
- R1: While `rst` is high, every output is 0 on the following edge. After reset the FP lane is free, even if a divide or square root was in progress when reset arrived.
- R2: The class bit `cls` is 0 for integer-side work (ALU, branch, load/store, FP load/store) and 1 for FP computation. A granted slot goes to the lane that its class selects. `int_from_s1` and `fp_from_s1` are 1 when that lane's instruction came from slot 1.
- R3: When both slots are valid, their classes differ and both lanes can accept, both lanes are granted and `consumed` is 2. This holds in either slot order.
- R4: When both slots are valid and have the same class, only slot 0 issues and `consumed` is 1.
- R5: Issue is in order. If slot 0 is invalid, or cannot go to its lane, nothing issues and `consumed` is 0. A slot that issues alone is always slot 0.
- R6: When `int_stall` is high, no instruction goes to the integer lane. When `fp_stall` is high, no instruction goes to the FP lane. The other lane still follows R3 to R5.
- R7: Kind code 2'b00 is a pipelined FP operation, covering single-precision add, subtract, multiply-add and convert. Operations of this kind can be granted on consecutive cycles.
- R8: Kind code 2'b01 is a double-precision multiply or multiply-add. After one is granted, no FP operation is granted on the next cycle. Integer-side issue continues during that cycle.
- R9: Kind code 2'b10 is a divide and 2'b11 is a square root. After one is granted, the FP lane grants nothing until `fp_long_done` has been seen high. FP issue resumes in the cycle after the strobe. A strobe that arrives while no such operation is pending has no effect.
- R10: `consumed` always equals the number of lane grants in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s0_valid | input | 1 | Slot 0 (older) holds an instruction |
| s0_cls | input | 1 | Slot 0 class: 0 integer-side, 1 FP computation |
| s0_kind | input | 2 | Slot 0 FP occupancy kind (used only when the class bit is 1) |
| s1_valid | input | 1 | Slot 1 (younger) holds an instruction |
| s1_cls | input | 1 | Slot 1 class |
| s1_kind | input | 2 | Slot 1 FP occupancy kind |
| int_stall | input | 1 | Integer lane cannot accept this cycle |
| fp_stall | input | 1 | FP lane cannot accept this cycle |
| fp_long_done | input | 1 | Pending divide or square root has completed |
| int_grant | output | 1 | Registered: an instruction was sent to the integer lane |
| int_from_s1 | output | 1 | Registered: the integer-lane instruction came from slot 1 |
| fp_grant | output | 1 | Registered: an instruction was sent to the FP lane |
| fp_from_s1 | output | 1 | Registered: the FP-lane instruction came from slot 1 |
| consumed | output | 2 | Registered: number of slots issued (0, 1 or 2) |

## Verification
The occupancy checks recover the kind of an issued FP operation from the slot kind inputs one cycle earlier. They therefore assume those kind inputs show the instruction that was actually decided on in that cycle. The stimulus changes the slots only at the falling edge and holds each pattern for exactly one decision. The completion strobe is assumed to come only from the lane's own divider. The bench follows this rule, except for one deliberate strobe sent while the lane is idle, which must have no effect.

// File: rtl/dip_pkg.sv
package dip_pkg;

  typedef enum logic [1:0] {
    FK_PIPE   = 2'b00,
    FK_DOUBLE = 2'b01,
    FK_DIV    = 2'b10,
    FK_SQRT   = 2'b11
  } fp_kind_e;

  typedef struct packed {
    logic can_go;
    logic is_fp;
    logic is_double;
    logic is_long;
  } slot_eval_t;

endpackage

// File: rtl/dip_slot_eval.sv
module dip_slot_eval
  import dip_pkg::*;
(
  input  logic       valid,
  input  logic       cls,
  input  logic [1:0] kind,
  input  logic       int_ok,
  input  logic       fp_ok,
  output slot_eval_t ev
);

  always_comb begin
    ev.is_fp     = cls;
    ev.can_go    = valid && (cls ? fp_ok : int_ok);
    ev.is_double = cls && (fp_kind_e'(kind) == FK_DOUBLE);
    ev.is_long   = cls && ((fp_kind_e'(kind) == FK_DIV) || (fp_kind_e'(kind) == FK_SQRT));
  end

endmodule

// File: rtl/dip_pair_select.sv
module dip_pair_select
  import dip_pkg::*;
(
  input  slot_eval_t ev0,
  input  slot_eval_t ev1,
  output logic       go0,
  output logic       go1
);

  always_comb begin
    go0 = ev0.can_go;
    go1 = ev0.can_go && ev1.can_go && (ev0.is_fp != ev1.is_fp);
  end

endmodule

// File: rtl/dip_fp_occupancy.sv
module dip_fp_occupancy #(
  parameter int DP_REPEAT = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic issue,
  input  logic issue_double,
  input  logic issue_long,
  input  logic long_done,
  output logic lane_free
);

  localparam int CW = (DP_REPEAT > 2) ? $clog2(DP_REPEAT) : 1;
  localparam logic [CW-1:0] GAP = CW'(DP_REPEAT - 1);

  logic [CW-1:0] gap_q;
  logic          long_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q  <= '0;
      long_q <= 1'b0;
    end else begin
      if (issue && issue_double)
        gap_q <= GAP;
      else if (gap_q != '0)
        gap_q <= gap_q - 1'b1;

      if (issue && issue_long)
        long_q <= 1'b1;
      else if (long_done)
        long_q <= 1'b0;
    end
  end

  assign lane_free = (gap_q == '0) && !long_q;

endmodule

// File: rtl/dual_issue_pair.sv
module dual_issue_pair
  import dip_pkg::*;
#(
  parameter int DP_REPEAT = 2,
  parameter int NSLOT     = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       s0_valid,
  input  logic       s0_cls,
  input  logic [1:0] s0_kind,
  input  logic       s1_valid,
  input  logic       s1_cls,
  input  logic [1:0] s1_kind,
  input  logic       int_stall,
  input  logic       fp_stall,
  input  logic       fp_long_done,
  output logic       int_grant,
  output logic       int_from_s1,
  output logic       fp_grant,
  output logic       fp_from_s1,
  output logic [1:0] consumed
);

  logic [NSLOT-1:0] v_in, c_in;
  logic [1:0]       k_in [NSLOT];
  slot_eval_t       ev   [NSLOT];
  logic             fp_free, go0, go1;

  assign v_in    = {s1_valid, s0_valid};
  assign c_in    = {s1_cls, s0_cls};
  assign k_in[0] = s0_kind;
  assign k_in[1] = s1_kind;

  genvar g;
  generate
    for (g = 0; g < NSLOT; g++) begin : g_slot
      dip_slot_eval i_eval (
        .valid  (v_in[g]),
        .cls    (c_in[g]),
        .kind   (k_in[g]),
        .int_ok (!int_stall),
        .fp_ok  (fp_free && !fp_stall),
        .ev     (ev[g])
      );
    end
  endgenerate

  dip_pair_select i_sel (
    .ev0 (ev[0]),
    .ev1 (ev[1]),
    .go0 (go0),
    .go1 (go1)
  );

  logic int_d, int_s1_d, fp_d, fp_s1_d, fp_dbl_d, fp_long_d;
  logic [1:0] cnt_d;

  always_comb begin
    int_s1_d  = go1 && !ev[1].is_fp;
    fp_s1_d   = go1 && ev[1].is_fp;
    int_d     = (go0 && !ev[0].is_fp) || int_s1_d;
    fp_d      = (go0 && ev[0].is_fp) || fp_s1_d;
    fp_dbl_d  = fp_s1_d ? ev[1].is_double : (fp_d && ev[0].is_double);
    fp_long_d = fp_s1_d ? ev[1].is_long   : (fp_d && ev[0].is_long);
    cnt_d     = {1'b0, go0} + {1'b0, go1};
  end

  dip_fp_occupancy #(.DP_REPEAT(DP_REPEAT)) i_occ (
    .clk          (clk),
    .rst          (rst),
    .issue        (fp_d),
    .issue_double (fp_dbl_d),
    .issue_long   (fp_long_d),
    .long_done    (fp_long_done),
    .lane_free    (fp_free)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      int_grant   <= 1'b0;
      int_from_s1 <= 1'b0;
      fp_grant    <= 1'b0;
      fp_from_s1  <= 1'b0;
      consumed    <= 2'd0;
    end else begin
      int_grant   <= int_d;
      int_from_s1 <= int_s1_d;
      fp_grant    <= fp_d;
      fp_from_s1  <= fp_s1_d;
      consumed    <= cnt_d;
    end
  end

endmodule

// File: rtl/dip_checker.sv
module dip_checker (
  input logic       clk,
  input logic       rst,
  input logic [1:0] s0_kind,
  input logic [1:0] s1_kind,
  input logic       fp_stall,
  input logic       int_grant,
  input logic       int_from_s1,
  input logic       fp_grant,
  input logic       fp_from_s1,
  input logic [1:0] consumed
);

  // R10
  count_matches_chk: assert property (@(posedge clk) disable iff (rst)
    consumed == ({1'b0, int_grant} + {1'b0, fp_grant}));

  // R4
  distinct_slots_chk: assert property (@(posedge clk) disable iff (rst)
    (int_grant && fp_grant) |-> (int_from_s1 != fp_from_s1));

  // R5
  older_alone_chk: assert property (@(posedge clk) disable iff (rst)
    (int_grant ^ fp_grant) |-> !(int_from_s1 || fp_from_s1));

  // R6
  fp_stall_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    $past(fp_stall) |-> !fp_grant);

  // R8
  double_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (fp_grant && ((fp_from_s1 ? $past(s1_kind) : $past(s0_kind)) == 2'b01)) |=> !fp_grant);

  // R9
  long_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (fp_grant && (fp_from_s1 ? $past(s1_kind[1]) : $past(s0_kind[1]))) |=> !fp_grant);

endmodule

bind dual_issue_pair dip_checker i_dip_chk (
  .clk         (clk),
  .rst         (rst),
  .s0_kind     (s0_kind),
  .s1_kind     (s1_kind),
  .fp_stall    (fp_stall),
  .int_grant   (int_grant),
  .int_from_s1 (int_from_s1),
  .fp_grant    (fp_grant),
  .fp_from_s1  (fp_from_s1),
  .consumed    (consumed)
);

// File: tb/test_dual_issue_pair.sv
module test_dual_issue_pair;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic s0_valid = 0, s0_cls = 0, s1_valid = 0, s1_cls = 0;
  logic [1:0] s0_kind = 0, s1_kind = 0;
  logic int_stall = 0, fp_stall = 0, fp_long_done = 0;
  logic int_grant, int_from_s1, fp_grant, fp_from_s1;
  logic [1:0] consumed;
  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  dual_issue_pair i_dual_issue_pair (
    .clk(clk), .rst(rst),
    .s0_valid(s0_valid), .s0_cls(s0_cls), .s0_kind(s0_kind),
    .s1_valid(s1_valid), .s1_cls(s1_cls), .s1_kind(s1_kind),
    .int_stall(int_stall), .fp_stall(fp_stall), .fp_long_done(fp_long_done),
    .int_grant(int_grant), .int_from_s1(int_from_s1),
    .fp_grant(fp_grant), .fp_from_s1(fp_from_s1), .consumed(consumed)
  );

  // stimulus {v0,c0,k0[1:0],v1,c1,k1[1:0],int_stall,fp_stall}
  // expect   {int_grant,fp_grant,int_from_s1,fp_from_s1,consumed[1:0]}
  localparam logic [15:0] VEC [12] = '{
    16'h8C36, // R3 int,fp -> both, count 2
    16'hC83A, // R3 R2 fp,int -> both, int from slot1
    16'h8821, // R4 int,int -> slot0 only
    16'hCC11, // R4 fp,fp -> slot0 only
    16'h0800, // R5 slot0 empty -> none
    16'h8021, // R2 int alone
    16'h8C80, // R5 R6 int stalled, older blocked -> none
    16'h8C61, // R6 fp stalled, int goes
    16'hC840, // R5 R6 fp older stalled -> none
    16'hC891, // R6 int stalled, fp older goes
    16'h0000, // R5 nothing valid
    16'h8CC0  // R6 both stalled
  };

  task automatic drive(input logic [9:0] in, input logic dn);
    {s0_valid, s0_cls, s0_kind, s1_valid, s1_cls, s1_kind, int_stall, fp_stall} = in;
    fp_long_done = dn;
  endtask

  task automatic check(input string tag, input logic [5:0] exp);
    logic [5:0] got;
    got = {int_grant, fp_grant, int_from_s1, fp_from_s1, consumed};
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%b exp=%b", tag, got, exp);
    end
  endtask

  task automatic step(input logic [9:0] in, input logic dn, input string tag, input logic [5:0] exp);
    drive(in, dn);
    @(posedge clk);
    @(negedge clk);
    check(tag, exp);
  endtask

  localparam logic [9:0] FP_PIPE_ALONE = 10'b1100_0000_00;
  localparam logic [9:0] FP_DBL_INT    = 10'b1101_1000_00;
  localparam logic [9:0] INT_FP_PIPE   = 10'b1000_1100_00;
  localparam logic [9:0] FP_PIPE_INT   = 10'b1100_1000_00;
  localparam logic [9:0] FP_DIV_ALONE  = 10'b1110_0000_00;
  localparam logic [9:0] FP_SQRT_ALONE = 10'b1111_0000_00;

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    drive(INT_FP_PIPE, 1'b0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset outputs", 6'b000000);
    rst = 1'b0;

    for (int i = 0; i < 12; i++)
      step(VEC[i][15:6], 1'b0, $sformatf("table row %0d", i), VEC[i][5:0]);

    // R7 pipelined FP every cycle
    for (int i = 0; i < 3; i++)
      step(FP_PIPE_INT, 1'b0, "R7 back-to-back pipelined", 6'b111010);

    // R8 double gap
    step(FP_DBL_INT,    1'b0, "R8 double issues",        6'b111010);
    step(INT_FP_PIPE,   1'b0, "R8 gap cycle int only",   6'b100001);
    step(FP_PIPE_ALONE, 1'b0, "R8 fp after gap",         6'b010001);
    step(FP_DBL_INT,    1'b0, "R8 double again",         6'b111010);
    step(FP_PIPE_ALONE, 1'b0, "R8 R5 older fp held",     6'b000000);
    step(FP_PIPE_ALONE, 1'b0, "R8 fp resumes",           6'b010001);

    // R9 divide until done
    step(FP_DIV_ALONE,  1'b0, "R9 divide issues",        6'b010001);
    step(FP_PIPE_ALONE, 1'b0, "R9 busy 1",               6'b000000);
    step(FP_PIPE_ALONE, 1'b0, "R9 busy 2",               6'b000000);
    step(INT_FP_PIPE,   1'b0, "R9 int continues",        6'b100001);
    step(FP_PIPE_ALONE, 1'b1, "R9 done cycle still held",6'b000000);
    step(FP_PIPE_ALONE, 1'b0, "R9 fp after done",        6'b010001);
    // R9 square root
    step(FP_SQRT_ALONE, 1'b0, "R9 sqrt issues",          6'b010001);
    step(FP_PIPE_ALONE, 1'b1, "R9 sqrt done cycle",      6'b000000);
    step(FP_PIPE_ALONE, 1'b0, "R9 fp after sqrt",        6'b010001);
    // R9 stray done ignored
    step(FP_PIPE_ALONE, 1'b1, "R9 idle done ignored",    6'b010001);
    step(FP_PIPE_ALONE, 1'b0, "R9 lane still free",      6'b010001);

    // R1 reset clears pending divide
    step(FP_DIV_ALONE,  1'b0, "R1 divide before reset",  6'b010001);
    rst = 1'b1;
    step(FP_PIPE_ALONE, 1'b0, "R1 outputs in reset",     6'b000000);
    rst = 1'b0;
    step(FP_PIPE_ALONE, 1'b0, "R1 fp free after reset",  6'b010001);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule